// File: doc/BRIEF.md
# USB Endpoint Pair Control and Receive Handshake

This block keeps the configuration of one endpoint pair of a USB device controller: for each direction an enable, a transfer type and a stall flag, and for the receive direction a data-toggle expectation with a self-clearing resynchronise bit and a toggle-inhibit bit. Software reaches it through a 32-bit write/read register port. The protocol engine pulses a strobe when a SETUP token arrives, and the stall flags then move on their own according to each direction's type.

For every received data packet the engine presents the data PID (DATA0 or DATA1), a CRC-good flag and whether buffer space is available. One cycle later the block returns the handshake to send (none, ACK, NAK or STALL) and whether the payload is to be kept. The stall flags are also driven out as status. Serialisation, CRC generation, DMA and buffer memory live elsewhere.

Top module: `usb_ep_ctl`

## Requirements
- R1: After reset every field reads 0: both directions disabled, not stalled, typed control (code 0), receive expectation DATA0; the handshake output is none (code 0) and accept is 0.
- R2: Register layout: receive stall bit 0, receive type bits 3:2, toggle inhibit bit 5, toggle resync bit 6, receive enable bit 7, transmit stall bit 16, transmit type bits 19:18, transmit enable bit 23; type codes 0 control, 1 isochronous, 2 bulk, 3 interrupt. Every other bit, including the resync bit and the data source/sink bits 17 and 1, reads 0, so writing all ones reads back 0x008D00AD.
- R3: With resync written, the receive expectation is DATA0. A CRC-good packet on an enabled, unstalled, non-isochronous receive direction with buffer space and a matching PID gives ACK with accept, and the expectation flips; a mismatching PID gives ACK without accept and leaves the expectation.
- R4: A packet while the receive enable is 0 gives no handshake and no accept.
- R5: A packet with a bad CRC gives no handshake, no accept and leaves the expectation unchanged.
- R6: Writing 1 to a stall bit makes that direction stalled until a write of 0 or a SETUP clears it; a stalled receive direction answers STALL to CRC-good packets and accepts nothing.
- R7: On a SETUP strobe each direction's stall bit becomes 1 if its type is not control and 0 if it is control.
- R8: A register write in the same cycle as a SETUP strobe decides the stall bits; the strobe has no effect in that cycle.
- R9: A CRC-good packet that would otherwise be ACKed while buffer space is lacking gets NAK, no accept, and the expectation is unchanged.
- R10: With toggle inhibit set, every CRC-good packet with buffer space is ACKed and accepted whatever its PID, and the expectation does not move.
- R11: An isochronous receive direction gives no handshake; it accepts each CRC-good packet when buffer space is available, and never moves the expectation.
- R12: Handshake code (0 none, 1 ACK, 2 NAK, 3 STALL) and accept are valid in the cycle after the packet strobe and are none/0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| setup_stb | input | 1 | SETUP token received |
| pkt_valid | input | 1 | Received data packet strobe |
| pkt_data1 | input | 1 | Packet PID: 1 DATA1, 0 DATA0 |
| pkt_crc_ok | input | 1 | Packet CRC good |
| buf_rdy | input | 1 | Buffer space available for the payload |
| hs_code | output | 2 | Handshake to send: 0 none, 1 ACK, 2 NAK, 3 STALL |
| pay_accept | output | 1 | Keep the payload |
| rx_stalled | output | 1 | Receive direction stalled |
| tx_stalled | output | 1 | Transmit direction stalled |
| tx_enabled | output | 1 | Transmit direction enabled |

## Verification
The bench pushes a repeated DATA0 after an accepted DATA0: a design that flips the expectation on a mismatch would accept the retry and then lose the next packet. It sends packets while the buffer is full, with a bad CRC and under toggle inhibit, where a design that moved the expectation anyway would drop or duplicate later data. It strobes SETUP on every pairing of control and non-control types, and together with a write, where a design that let the strobe win would leave a stall set that software just cleared. It writes all ones to find reserved bits or the self-clearing resync bit that read back non-zero.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int REG_W      = 32;
  localparam int RX_STALL_B = 0;
  localparam int RX_KIND_LO = 2;
  localparam int RX_INH_B   = 5;
  localparam int RX_RSYNC_B = 6;
  localparam int RX_EN_B    = 7;
  localparam int TX_STALL_B = 16;
  localparam int TX_KIND_LO = 18;
  localparam int TX_EN_B    = 23;

  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_kind_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;
endpackage

// File: rtl/usb_ep_cfg.sv
module usb_ep_cfg
  import usb_ep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             setup_stb,
  output logic [REG_W-1:0] rdata,
  output logic             rx_en,
  output ep_kind_e         rx_kind,
  output logic             rx_stall,
  output logic             rx_inh,
  output logic             rsync_pulse,
  output logic             tx_en,
  output ep_kind_e         tx_kind,
  output logic             tx_stall
);
  logic     rx_en_q, rx_en_d, rx_inh_q, rx_inh_d;
  logic     rx_stall_q, rx_stall_d, tx_stall_q, tx_stall_d;
  logic     tx_en_q, tx_en_d;
  ep_kind_e rx_kind_q, rx_kind_d, tx_kind_q, tx_kind_d;

  always_comb begin
    rx_en_d    = rx_en_q;
    rx_inh_d   = rx_inh_q;
    rx_kind_d  = rx_kind_q;
    rx_stall_d = rx_stall_q;
    tx_en_d    = tx_en_q;
    tx_kind_d  = tx_kind_q;
    tx_stall_d = tx_stall_q;
    if (wr_en) begin
      rx_en_d    = wdata[RX_EN_B];
      rx_inh_d   = wdata[RX_INH_B];
      rx_kind_d  = ep_kind_e'(wdata[RX_KIND_LO +: 2]);
      rx_stall_d = wdata[RX_STALL_B];
      tx_en_d    = wdata[TX_EN_B];
      tx_kind_d  = ep_kind_e'(wdata[TX_KIND_LO +: 2]);
      tx_stall_d = wdata[TX_STALL_B];
    end else if (setup_stb) begin
      rx_stall_d = (rx_kind_q != EP_CTRL);
      tx_stall_d = (tx_kind_q != EP_CTRL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q    <= 1'b0;
      rx_inh_q   <= 1'b0;
      rx_kind_q  <= EP_CTRL;
      rx_stall_q <= 1'b0;
      tx_en_q    <= 1'b0;
      tx_kind_q  <= EP_CTRL;
      tx_stall_q <= 1'b0;
    end else begin
      rx_en_q    <= rx_en_d;
      rx_inh_q   <= rx_inh_d;
      rx_kind_q  <= rx_kind_d;
      rx_stall_q <= rx_stall_d;
      tx_en_q    <= tx_en_d;
      tx_kind_q  <= tx_kind_d;
      tx_stall_q <= tx_stall_d;
    end
  end

  always_comb begin
    rdata                   = '0;
    rdata[RX_STALL_B]       = rx_stall_q;
    rdata[RX_KIND_LO +: 2]  = rx_kind_q;
    rdata[RX_INH_B]         = rx_inh_q;
    rdata[RX_EN_B]          = rx_en_q;
    rdata[TX_STALL_B]       = tx_stall_q;
    rdata[TX_KIND_LO +: 2]  = tx_kind_q;
    rdata[TX_EN_B]          = tx_en_q;
  end

  assign rsync_pulse = wr_en & wdata[RX_RSYNC_B];
  assign rx_en    = rx_en_q;
  assign rx_kind  = rx_kind_q;
  assign rx_stall = rx_stall_q;
  assign rx_inh   = rx_inh_q;
  assign tx_en    = tx_en_q;
  assign tx_kind  = tx_kind_q;
  assign tx_stall = tx_stall_q;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[REG_W-1:TX_EN_B+1], wdata[TX_EN_B-1:TX_KIND_LO+2],
                          wdata[TX_STALL_B+1], wdata[TX_STALL_B-1:RX_EN_B+1],
                          wdata[RX_KIND_LO+2], wdata[RX_STALL_B+1]};

  AST_SETUP_SETS_RX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_stb && !wr_en && rx_kind_q != EP_CTRL) |=> rx_stall_q); // R7
  AST_SETUP_CLEARS_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_stb && !wr_en && tx_kind_q == EP_CTRL) |=> !tx_stall_q); // R7
  AST_WRITE_BEATS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rx_stall_q == $past(wdata[RX_STALL_B])) && (tx_stall_q == $past(wdata[TX_STALL_B]))); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !setup_stb) |=> $stable(rx_stall_q) && $stable(tx_stall_q)); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[RX_RSYNC_B] == 1'b0) && (rdata[15:8] == 8'h00) && (rdata[REG_W-1:24] == '0)); // R2
endmodule

// File: rtl/usb_ep_rx_seq.sv
module usb_ep_rx_seq
  import usb_ep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_en,
  input  ep_kind_e rx_kind,
  input  logic     rx_stall,
  input  logic     rx_inh,
  input  logic     rsync_pulse,
  input  logic     pkt_valid,
  input  logic     pkt_data1,
  input  logic     pkt_crc_ok,
  input  logic     buf_rdy,
  output hs_e      hs_code,
  output logic     pay_accept
);
  logic exp_d1_q, exp_d1_d;
  hs_e  hs_q, hs_d;
  logic acc_q, acc_d;
  logic pkt_live;

  assign pkt_live = pkt_valid && rx_en && pkt_crc_ok;

  always_comb begin
    hs_d     = HS_NONE;
    acc_d    = 1'b0;
    exp_d1_d = exp_d1_q;
    if (pkt_live) begin
      if (rx_stall) begin
        hs_d = HS_STALL;
      end else if (rx_kind == EP_ISO) begin
        acc_d = buf_rdy;
      end else if (!buf_rdy) begin
        hs_d = HS_NAK;
      end else begin
        hs_d = HS_ACK;
        if (rx_inh) begin
          acc_d = 1'b1;
        end else if (pkt_data1 == exp_d1_q) begin
          acc_d    = 1'b1;
          exp_d1_d = ~exp_d1_q;
        end
      end
    end
    if (rsync_pulse) exp_d1_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_d1_q <= 1'b0;
      hs_q     <= HS_NONE;
      acc_q    <= 1'b0;
    end else begin
      exp_d1_q <= exp_d1_d;
      hs_q     <= hs_d;
      acc_q    <= acc_d;
    end
  end

  assign hs_code    = hs_q;
  assign pay_accept = acc_q;

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !rx_en) |=> (hs_q == HS_NONE) && !acc_q); // R4
  AST_BADCRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_crc_ok) |=> (hs_q == HS_NONE) && !acc_q); // R5
  AST_STALL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_live && rx_stall) |=> (hs_q == HS_STALL) && !acc_q); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (hs_q == HS_NONE) && !acc_q); // R12
  AST_EXPECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid && !rsync_pulse) |=> $stable(exp_d1_q)); // R3
  AST_RSYNC_DATA0: assert property (@(posedge clk) disable iff (!rst_n)
    rsync_pulse |=> !exp_d1_q); // R3
endmodule

// File: rtl/usb_ep_ctl.sv
module usb_ep_ctl
  import usb_ep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             setup_stb,
  input  logic             pkt_valid,
  input  logic             pkt_data1,
  input  logic             pkt_crc_ok,
  input  logic             buf_rdy,
  output logic [1:0]       hs_code,
  output logic             pay_accept,
  output logic             rx_stalled,
  output logic             tx_stalled,
  output logic             tx_enabled
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic     rx_en, rx_stall, rx_inh, rsync_pulse, tx_en, tx_stall;
  ep_kind_e rx_kind, tx_kind;
  hs_e      hs_int;

  usb_ep_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (reg_wr),
    .wdata      (reg_wdata),
    .setup_stb  (setup_stb),
    .rdata      (reg_rdata),
    .rx_en      (rx_en),
    .rx_kind    (rx_kind),
    .rx_stall   (rx_stall),
    .rx_inh     (rx_inh),
    .rsync_pulse(rsync_pulse),
    .tx_en      (tx_en),
    .tx_kind    (tx_kind),
    .tx_stall   (tx_stall)
  );

  usb_ep_rx_seq u_rx (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rx_en      (rx_en),
    .rx_kind    (rx_kind),
    .rx_stall   (rx_stall),
    .rx_inh     (rx_inh),
    .rsync_pulse(rsync_pulse),
    .pkt_valid  (pkt_valid),
    .pkt_data1  (pkt_data1),
    .pkt_crc_ok (pkt_crc_ok),
    .buf_rdy    (buf_rdy),
    .hs_code    (hs_int),
    .pay_accept (pay_accept)
  );

  logic unused_kind;
  assign unused_kind = ^tx_kind;

  assign hs_code    = hs_int;
  assign rx_stalled = rx_stall;
  assign tx_stalled = tx_stall;
  assign tx_enabled = tx_en;
endmodule

// File: tb/usb_ep_ctl_tb.sv
module usb_ep_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        setup_stb = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_data1 = 1'b0;
  logic        pkt_crc_ok = 1'b0;
  logic        buf_rdy = 1'b0;
  logic [1:0]  hs_code;
  logic        pay_accept, rx_stalled, tx_stalled, tx_enabled;
  int          n_chk = 0;
  int          n_bad = 0;

  localparam logic [1:0] NONE = 2'd0, ACK = 2'd1, NAK = 2'd2, STALL = 2'd3;

  always #2.5 clk = ~clk;

  usb_ep_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .setup_stb(setup_stb), .pkt_valid(pkt_valid),
    .pkt_data1(pkt_data1), .pkt_crc_ok(pkt_crc_ok), .buf_rdy(buf_rdy),
    .hs_code(hs_code), .pay_accept(pay_accept), .rx_stalled(rx_stalled),
    .tx_stalled(tx_stalled), .tx_enabled(tx_enabled)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic with_setup);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d; setup_stb = with_setup;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; setup_stb = 1'b0;
  endtask

  task automatic setup();
    @(negedge clk);
    setup_stb = 1'b1;
    @(negedge clk);
    setup_stb = 1'b0;
  endtask

  task automatic pkt(input string tag, input logic d1, input logic crc, input logic rdy,
                     input logic [1:0] exp_hs, input logic exp_acc);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data1 = d1; pkt_crc_ok = crc; buf_rdy = rdy;
    @(negedge clk);
    pkt_valid = 1'b0; pkt_data1 = 1'b0; pkt_crc_ok = 1'b0; buf_rdy = 1'b0;
    chk({tag, " hs"}, {30'd0, hs_code}, {30'd0, exp_hs});
    chk({tag, " acc"}, {31'd0, pay_accept}, {31'd0, exp_acc});
    @(negedge clk);
    chk({tag, " quiet R12"}, {29'd0, hs_code, pay_accept}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 hs", {30'd0, hs_code}, 32'd0);
    chk("R1 stalls", {29'd0, rx_stalled, tx_stalled, pay_accept}, 32'd0);
    wr(32'h0000_0080, 1'b0);           // enable rx, control type, no resync
    pkt("R1 expect DATA0", 1'b0, 1'b1, 1'b1, ACK, 1'b1);
    wr(32'h0, 1'b0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF, 1'b0);
    chk("R2 readback ones", reg_rdata, 32'h008D_00AD);
    chk("R2 tx enable", {31'd0, tx_enabled}, 32'd1);
    wr(32'h0, 1'b0);
    chk("R2 readback zero", reg_rdata, 32'h0);
  endtask

  task automatic t_disabled();
    wr(32'h0000_0048, 1'b0);           // bulk, resync, disabled
    pkt("R4 disabled", 1'b0, 1'b1, 1'b1, NONE, 1'b0);
  endtask

  task automatic t_sequence();
    wr(32'h0000_00C8, 1'b0);           // enable, bulk, resync
    pkt("R3 DATA0 match", 1'b0, 1'b1, 1'b1, ACK, 1'b1);
    pkt("R3 DATA0 repeat", 1'b0, 1'b1, 1'b1, ACK, 1'b0);
    pkt("R3 DATA1 match", 1'b1, 1'b1, 1'b1, ACK, 1'b1);
    pkt("R9 NAK no room", 1'b0, 1'b1, 1'b0, NAK, 1'b0);
    pkt("R5 bad crc", 1'b0, 1'b0, 1'b1, NONE, 1'b0);
    pkt("R3 DATA0 after hold", 1'b0, 1'b1, 1'b1, ACK, 1'b1);
    wr(32'h0000_00C8, 1'b0);           // resync mid-stream
    pkt("R3 resync DATA1 wrong", 1'b1, 1'b1, 1'b1, ACK, 1'b0);
    pkt("R3 resync DATA0", 1'b0, 1'b1, 1'b1, ACK, 1'b1);
  endtask

  task automatic t_inhibit();
    wr(32'h0000_00E8, 1'b0);           // enable, resync, inhibit, bulk
    pkt("R10 DATA1", 1'b1, 1'b1, 1'b1, ACK, 1'b1);
    pkt("R10 DATA1 again", 1'b1, 1'b1, 1'b1, ACK, 1'b1);
    wr(32'h0000_0088, 1'b0);           // inhibit off, no resync
    pkt("R10 expectation kept DATA0", 1'b0, 1'b1, 1'b1, ACK, 1'b1);
  endtask

  task automatic t_iso();
    wr(32'h0000_00C4, 1'b0);           // enable, iso, resync
    pkt("R11 iso DATA1", 1'b1, 1'b1, 1'b1, NONE, 1'b1);
    pkt("R11 iso no room", 1'b0, 1'b1, 1'b0, NONE, 1'b0);
    pkt("R11 iso bad crc", 1'b0, 1'b0, 1'b1, NONE, 1'b0);
    wr(32'h0000_0088, 1'b0);
    pkt("R11 expectation still DATA0", 1'b1, 1'b1, 1'b1, ACK, 1'b0);
  endtask

  task automatic t_stall();
    wr(32'h0000_00C9, 1'b0);           // enable, bulk, stall, resync
    chk("R6 rx stalled", {31'd0, rx_stalled}, 32'd1);
    pkt("R6 stall answer", 1'b0, 1'b1, 1'b1, STALL, 1'b0);
    pkt("R6 stall bad crc", 1'b0, 1'b0, 1'b1, NONE, 1'b0);
    chk("R6 stall persists", {31'd0, rx_stalled}, 32'd1);
    wr(32'h0000_0088, 1'b0);
    chk("R6 stall cleared", {31'd0, rx_stalled}, 32'd0);
    pkt("R6 after stall DATA0", 1'b0, 1'b1, 1'b1, ACK, 1'b1);
  endtask

  task automatic t_setup();
    wr(32'h0001_0088, 1'b0);           // rx bulk, tx control stalled
    setup();
    chk("R7 rx bulk set", {31'd0, rx_stalled}, 32'd1);
    chk("R7 tx control cleared", {31'd0, tx_stalled}, 32'd0);
    wr(32'h000C_0081, 1'b0);           // rx control stalled, tx interrupt
    setup();
    chk("R7 rx control cleared", {31'd0, rx_stalled}, 32'd0);
    chk("R7 tx interrupt set", {31'd0, tx_stalled}, 32'd1);
    chk("R7 readback", reg_rdata, 32'h000D_0080);
  endtask

  task automatic t_priority();
    wr(32'h0000_0088, 1'b0);           // rx bulk, not stalled
    wr(32'h0000_0088, 1'b1);           // same write with SETUP
    chk("R8 write keeps clear", {31'd0, rx_stalled}, 32'd0);
    wr(32'h0000_0081, 1'b0);           // rx control stalled
    wr(32'h0000_0081, 1'b1);
    chk("R8 write keeps stall", {31'd0, rx_stalled}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_layout();
    t_disabled();
    t_sequence();
    t_inhibit();
    t_iso();
    t_stall();
    t_setup();
    t_priority();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule